// File: doc/BRIEF.md
# Asynchronous Serial Receive Channel with Error Flags

This block receives characters from an asynchronous serial line. A programmable divider makes a sampling tick every `baud_div + 1` clocks, and sixteen ticks make one bit period. The line passes through a two-flop synchronizer. A falling edge while idle starts a frame. The start bit is confirmed at its middle, and every later bit is sampled at its middle. A frame holds 7 or 8 data bits sent LSB first, an optional even or odd parity bit, and one or two stop bits.

When the first stop bit is sampled, the assembled character moves into the receive buffer. The buffer-full flag and all error flags are updated on that same cycle: overrun, parity, framing, and a summing flag that is the OR of those three. The host clears buffer-full by reading the buffer with `buf_rd`. Any status write (`stat_wr`) clears the error flags. Taking `cfg_en` low clears every flag and holds the receiver idle. A one-cycle interrupt pulse marks each rise of buffer-full.

Top module: `uart_rx_chan`

## Requirements
- R1: A frame sent LSB first at 16*(baud_div+1) clocks per bit is placed in `rx_data`. `status[1]` (buffer full) is set on the cycle the first stop bit is sampled.
- R2: With `cfg_seven`=1, 7 data bits are received and `rx_data[7]` reads 0.
- R3: With `cfg_par_en`=1, a parity bit follows the data. It is even when `cfg_par_odd`=0 and odd when `cfg_par_odd`=1. A mismatch sets `status[4]`.
- R4: A first stop bit sampled as 0 sets `status[5]` (framing). In two-stop mode the character and all flags are still captured at the first stop bit.
- R5: If a character completes while `status[1]` is 1 and no read occurs on that cycle, `status[3]` (overrun) is set. `rx_data` takes the new character.
- R6: `status[6]` equals the OR of `status[3]`, `status[4]` and `status[5]`.
- R7: A `buf_rd` pulse clears `status[1]` and leaves the error flags unchanged.
- R8: A `stat_wr` pulse clears `status[6:3]` and leaves `status[1]` unchanged.
- R9: While `cfg_en`=0, `status` reads 0 and line activity receives nothing.
- R10: `rx_irq` is high for exactly one cycle each time `status[1]` goes from 0 to 1. It does not pulse on an overrun, when `status[1]` stays 1.
- R11: A low pulse shorter than half a bit period on an idle line is rejected as a false start and receives no character.
- R12: After reset, `status` and `rx_data` are 0. `status[0]`, `status[2]` and `status[7]` always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_in | input | 1 | Serial receive line, idles high |
| cfg_en | input | 1 | Serial enable; 0 clears all flags and idles the receiver |
| cfg_seven | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 expects a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 selects even |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| baud_div | input | DIV_W | Tick divider; one tick every baud_div+1 clocks |
| buf_rd | input | 1 | One-cycle receive buffer read strobe |
| stat_wr | input | 1 | One-cycle status write strobe |
| rx_data | output | 8 | Receive buffer contents |
| status | output | 8 | {0, sum, framing, parity, overrun, 0, full, 0} |
| rx_irq | output | 1 | Receive interrupt pulse |

## Verification
The in-RTL assertions check the clearing rules on every cycle: reads against buffer-full, status writes against the error flags, and disable against the whole status. They also check that the interrupt coincides with a rise of buffer-full, that overrun is captured on a load into a full buffer, and that a 7-bit load produces a zero top bit. Only the bench's frames can show that the bit timing, LSB-first assembly, parity polarity, stop-bit checking and false-start rejection give the right character and flags. It drives random formats, data and injected errors, mixed with directed overrun, glitch and disable cases.

// File: rtl/uart_rx_chan.sv
module uart_rx_chan #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_in,
  input  logic             cfg_en,
  input  logic             cfg_seven,
  input  logic             cfg_par_en,
  input  logic             cfg_par_odd,
  input  logic             cfg_two_stop,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             buf_rd,
  input  logic             stat_wr,
  output logic [7:0]       rx_data,
  output logic [7:0]       status,
  output logic             rx_irq
);

  localparam int OS_W = 4;
  localparam logic [OS_W-1:0] OS_MID  = OS_W'(7);
  localparam logic [OS_W-1:0] OS_LAST = OS_W'(15);

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_PAR, S_STOP1, S_STOP2} st_t;

  st_t             st;
  logic            sync1, sync2, prev;
  logic [DIV_W-1:0] cnt;
  logic [OS_W-1:0] os;
  logic [2:0]      bitn;
  logic [7:0]      sh;
  logic            pacc, perr;
  logic            rbf, rbf_d, oe, pe, fe;

  wire tick     = (cnt == baud_div);
  wire fall     = prev & ~sync2;
  wire mid      = tick && (os == OS_MID);
  wire bit_end  = tick && (os == OS_LAST);
  wire last_bit = (bitn == (cfg_seven ? 3'd6 : 3'd7));
  wire load     = (st == S_STOP1) && bit_end;
  wire ovr_now  = rbf & ~buf_rd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= 1'b1;
      sync2 <= 1'b1;
      prev  <= 1'b1;
    end else begin
      sync1 <= rx_in;
      sync2 <= sync1;
      prev  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      cnt     <= '0;
      os      <= '0;
      bitn    <= '0;
      sh      <= '0;
      pacc    <= 1'b0;
      perr    <= 1'b0;
      rbf     <= 1'b0;
      oe      <= 1'b0;
      pe      <= 1'b0;
      fe      <= 1'b0;
      rx_data <= '0;
    end else if (!cfg_en) begin
      st  <= S_IDLE;
      cnt <= '0;
      os  <= '0;
      rbf <= 1'b0;
      oe  <= 1'b0;
      pe  <= 1'b0;
      fe  <= 1'b0;
    end else begin
      cnt <= ((st == S_IDLE && fall) || tick) ? '0 : cnt + 1'b1;
      if (st != S_IDLE && tick) os <= os + 1'b1;
      case (st)
        S_IDLE:
          if (fall) begin
            st <= S_START;
            os <= '0;
          end
        S_START:
          if (mid) begin
            if (sync2) st <= S_IDLE;
            else begin
              st   <= S_DATA;
              os   <= '0;
              bitn <= '0;
              pacc <= 1'b0;
              perr <= 1'b0;
            end
          end
        S_DATA:
          if (bit_end) begin
            sh   <= {sync2, sh[7:1]};
            pacc <= pacc ^ sync2;
            bitn <= bitn + 1'b1;
            if (last_bit) st <= cfg_par_en ? S_PAR : S_STOP1;
          end
        S_PAR:
          if (bit_end) begin
            perr <= pacc ^ sync2 ^ cfg_par_odd;
            st   <= S_STOP1;
          end
        S_STOP1:
          if (bit_end) st <= cfg_two_stop ? S_STOP2 : S_IDLE;
        S_STOP2:
          if (bit_end) st <= S_IDLE;
        default: st <= S_IDLE;
      endcase
      if (buf_rd) rbf <= 1'b0;
      if (stat_wr) begin
        oe <= 1'b0;
        pe <= 1'b0;
        fe <= 1'b0;
      end
      if (load) begin
        rbf     <= 1'b1;
        rx_data <= cfg_seven ? {1'b0, sh[7:1]} : sh;
        if (ovr_now) oe <= 1'b1;
        if (perr)    pe <= 1'b1;
        if (!sync2)  fe <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rbf_d <= 1'b0;
    else        rbf_d <= rbf;
  end

  assign rx_irq = rbf & ~rbf_d;
  assign status = {1'b0, oe | pe | fe, fe, pe, oe, 1'b0, rbf, 1'b0};

  p_seven_msb_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && load && cfg_seven) |=> !rx_data[7]);

  p_ovr_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && load && rbf && !buf_rd) |=> status[3]);

  p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && buf_rd && !load) |=> !status[1]);

  p_write_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_en && stat_wr && !load) |=> (status[6:3] == 4'b0));

  p_disable_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |=> (status == 8'h00));

  p_irq_on_rise_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rx_irq |-> $rose(status[1]));

endmodule

// File: tb/uart_rx_chan_bench.sv
module uart_rx_chan_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_in = 1'b1;
  logic cfg_en = 1'b0, cfg_seven = 1'b0, cfg_par_en = 1'b0, cfg_par_odd = 1'b0, cfg_two_stop = 1'b0;
  logic [7:0] baud_div = 8'd0;
  logic buf_rd = 1'b0, stat_wr = 1'b0;
  logic [7:0] rx_data, status;
  logic rx_irq;

  int checks = 0, fails = 0, irq_cnt = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  uart_rx_chan #(.DIV_W(8)) u_uart_rx_chan (
    .clk(clk), .rst_n(rst_n), .rx_in(rx_in), .cfg_en(cfg_en), .cfg_seven(cfg_seven),
    .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_two_stop(cfg_two_stop),
    .baud_div(baud_div), .buf_rd(buf_rd), .stat_wr(stat_wr),
    .rx_data(rx_data), .status(status), .rx_irq(rx_irq));

  always @(posedge clk) if (rx_irq) irq_cnt++;

  function automatic logic [7:0] exp_data(input logic [7:0] d, input logic seven);
    return seven ? {1'b0, d[6:0]} : d;
  endfunction

  function automatic logic [7:0] exp_stat(input logic rbf, input logic oe, input logic pe, input logic fe);
    return {1'b0, oe | pe | fe, fe, pe, oe, 1'b0, rbf, 1'b0};
  endfunction

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic send_bit(input logic v);
    rx_in = v;
    repeat (16 * (int'(baud_div) + 1)) @(negedge clk);
  endtask

  task automatic send_frame(input logic [7:0] d, input logic bad_par, input logic bad_stop);
    logic [7:0] m;
    m = exp_data(d, cfg_seven);
    send_bit(1'b0);
    for (int i = 0; i < (cfg_seven ? 7 : 8); i++) send_bit(d[i]);
    if (cfg_par_en) send_bit((^m) ^ cfg_par_odd ^ bad_par);
    send_bit(!bad_stop);
    if (cfg_two_stop) send_bit(1'b1);
    send_bit(1'b1);
    send_bit(1'b1);
  endtask

  task automatic pulse_rd();
    @(negedge clk) buf_rd = 1'b1;
    @(negedge clk) buf_rd = 1'b0;
  endtask

  task automatic pulse_wr();
    @(negedge clk) stat_wr = 1'b1;
    @(negedge clk) stat_wr = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int seed;
    int irq0;
    logic [7:0] d;
    logic bp, bs;
    seed = 7;
    void'($urandom(seed));
    repeat (3) @(negedge clk);
    chk("R12 reset status", status, 8'h00);
    chk("R12 reset data", rx_data, 8'h00);
    rst_n = 1'b1;
    cfg_en = 1'b1;
    baud_div = 8'd1;
    repeat (4) @(negedge clk);

    irq0 = irq_cnt;
    send_frame(8'hA5, 1'b0, 1'b0);
    chk("R1 data 8N1", rx_data, 8'hA5);
    chk("R1 status full", status, exp_stat(1, 0, 0, 0));
    chk("R10 one irq", irq_cnt - irq0, 1);
    pulse_rd();
    chk("R7 read clears full", status, 8'h00);

    cfg_seven = 1'b1;
    send_frame(8'hFF, 1'b0, 1'b0);
    chk("R2 seven bit msb zero", rx_data, 8'h7F);
    pulse_rd();

    cfg_seven = 1'b0;
    cfg_par_en = 1'b1;
    cfg_par_odd = 1'b1;
    send_frame(8'h3C, 1'b1, 1'b0);
    chk("R3 odd parity error", status, exp_stat(1, 0, 1, 0));
    pulse_rd();
    chk("R7 read keeps errors", status, exp_stat(0, 0, 1, 0));
    pulse_wr();
    chk("R8 write clears errors", status, 8'h00);

    cfg_par_en = 1'b0;
    cfg_two_stop = 1'b1;
    send_frame(8'h5A, 1'b0, 1'b1);
    chk("R4 framing two stop", status, exp_stat(1, 0, 0, 1));
    chk("R4 data captured", rx_data, 8'h5A);
    pulse_wr();
    chk("R8 write keeps full", status, exp_stat(1, 0, 0, 0));
    pulse_rd();

    cfg_two_stop = 1'b0;
    irq0 = irq_cnt;
    send_frame(8'h11, 1'b0, 1'b0);
    send_frame(8'h22, 1'b0, 1'b0);
    chk("R5 overrun flag", status, exp_stat(1, 1, 0, 0));
    chk("R5 data replaced", rx_data, 8'h22);
    chk("R10 no irq on overrun", irq_cnt - irq0, 1);
    chk("R6 summing", status[6], 1'b1);

    @(negedge clk) cfg_en = 1'b0;
    @(negedge clk);
    chk("R9 disable clears", status, 8'h00);
    send_frame(8'h66, 1'b0, 1'b0);
    chk("R9 ignored while off", status, 8'h00);
    cfg_en = 1'b1;
    repeat (4) @(negedge clk);

    irq0 = irq_cnt;
    rx_in = 1'b0;
    repeat (8) @(negedge clk);
    rx_in = 1'b1;
    repeat (96) @(negedge clk);
    chk("R11 glitch status", status, 8'h00);
    chk("R11 glitch irq", irq_cnt - irq0, 0);

    for (int k = 0; k < 40; k++) begin
      baud_div = 8'($urandom_range(0, 3));
      cfg_seven = 1'($urandom);
      cfg_par_en = 1'($urandom);
      cfg_par_odd = 1'($urandom);
      cfg_two_stop = 1'($urandom);
      d = 8'($urandom);
      bp = cfg_par_en && ($urandom_range(0, 3) == 0);
      bs = ($urandom_range(0, 4) == 0);
      repeat (4) @(negedge clk);
      irq0 = irq_cnt;
      send_frame(d, bp, bs);
      chk("R1 R2 random data", rx_data, exp_data(d, cfg_seven));
      chk("R3 R4 R6 random status", status, exp_stat(1, 0, bp, bs));
      chk("R10 random irq", irq_cnt - irq0, 1);
      pulse_rd();
      pulse_wr();
      chk("R7 R8 random cleared", status, 8'h00);
    end

    finish_run();
  end
endmodule